// File: doc/BRIEF.md
# Tick Compare Interrupt Timer

This block keeps one free-running 63-bit tick counter and several 64-bit compare channels that all measure against it. Typical use is three channels: a processor tick, a system tick and a hypervisor system tick, where the hypervisor channel has no counter of its own and reads the shared one. Software writes a compare channel or the counter through a single write port and reads any of them back through a read port.

The most significant bit of each compare register is a disable flag; the lower 63 bits are the target. A compare write always drops whatever event that channel had pending. The channel then arms again only when the flag is clear and the target lies strictly ahead of the count seen at the write. An armed channel fires one single-cycle match pulse when the count reaches its target and then stays quiet until it is written again. A downstream interrupt block turns each pulse into a pending soft-interrupt bit.

Top module: `tick_match_timer`

## Requirements
- R1: After reset the count is zero, no channel is armed, no match pulse is high, and every compare register reads back as 64'h8000_0000_0000_0000 (disable flag set, target zero).
- R2: With no counter write, the count rises by exactly one every clock and wraps from 2^63-1 to 0.
- R3: A write with `wrSel` equal to NUM_CMP loads `wrData[62:0]` into the counter. The loaded value is visible in the next cycle and counting resumes from it.
- R4: A write with `wrSel` equal to a channel index i (0 to NUM_CMP-1) stores all 64 bits of `wrData` into compare register i. `rdSel`=i returns that value unchanged, including bit 63. `rdSel`=NUM_CMP returns the count with bit 63 zero.
- R5: A compare write arms the channel only when bit 63 is 0 and the target bits are strictly greater than the count at the write. A target equal to or below that count, or a set disable flag, leaves the channel unarmed, so it produces no pulse.
- R6: An armed channel raises `matchPulse[i]` for exactly one cycle, in the cycle after the count equals its target. It then disarms, and the count passing the target again does not fire it.
- R7: A compare write to a channel cancels that channel's pending event, and this holds even in the cycle the count meets the old target: no pulse follows for the old target.
- R8: A counter load neither cancels nor re-arms any channel. An armed channel still fires when the reloaded count reaches its target, also when the load falls in the match cycle.
- R9: All channels compare against the same counter and arm independently. Channels with equal targets pulse in the same cycle.
- R10: A write with `wrSel` above NUM_CMP changes no compare register and does not disturb the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| wrSel | input | SEL_W (3) | Write target: channel index, NUM_CMP for the counter |
| wrData | input | CNT_W+1 (64) | Write data; bit 63 is the disable flag for compare writes |
| rdSel | input | SEL_W (3) | Read select: channel index or NUM_CMP for the counter |
| rdData | output | CNT_W+1 (64) | Selected compare register or zero-extended count |
| count | output | CNT_W (63) | Current shared tick count |
| matchPulse | output | NUM_CMP (3) | One-cycle match pulse per channel |

## Verification
Two kinds of collision can happen in one cycle. A compare write can land in the cycle a channel's count meets its armed target, and a counter load can land in that cycle too. The bench provokes both by arming a target three counts ahead, idling two cycles, and then issuing the write or the load in the hit cycle. A compare write there must swallow the pulse, while a counter load must let it through and must not arm the channel again.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  // widest channel index carried in the strobe bundle
  localparam int IDX_W = 4;

  typedef struct packed {
    logic             cntLoad;   // load the shared counter
    logic             cmpWrite;  // write one compare channel
    logic [IDX_W-1:0] cmpIdx;    // which channel
  } tmr_strobe_t;

endpackage

// File: rtl/tick_timer_dp.sv
module tick_timer_dp
  import tick_timer_pkg::*;
#(
  parameter int NUM_CMP = 3,
  parameter int CNT_W   = 63,
  parameter int SEL_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  tmr_strobe_t        strb,
  input  logic [CNT_W:0]     wrData,
  input  logic [SEL_W-1:0]   rdSel,
  output logic [CNT_W:0]     rdData,
  output logic [CNT_W-1:0]   count,
  output logic [NUM_CMP-1:0] hitVec,
  output logic               armOk
);

  localparam int CMP_W = CNT_W + 1;
  localparam logic [CMP_W-1:0] CMP_RESET = {1'b1, {CNT_W{1'b0}}};

  logic [CNT_W-1:0] countQ;
  logic [CMP_W-1:0] cmpReg [NUM_CMP];

  // shared free-running counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            countQ <= '0;
    else if (strb.cntLoad) countQ <= wrData[CNT_W-1:0];
    else                   countQ <= countQ + 1'b1;
  end

  assign count = countQ;

  // arming qualifier for a compare write: enabled and strictly ahead
  assign armOk = !wrData[CNT_W] && (wrData[CNT_W-1:0] > countQ);

  for (genvar g = 0; g < NUM_CMP; g++) begin : gCmp
    logic wrThis;
    assign wrThis = strb.cmpWrite && (strb.cmpIdx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cmpReg[g] <= CMP_RESET;
      else if (wrThis) cmpReg[g] <= wrData;
    end

    assign hitVec[g] = (cmpReg[g][CNT_W-1:0] == countQ);
  end

  always_comb begin
    rdData = '0;
    if (rdSel == SEL_W'(NUM_CMP)) rdData = {1'b0, countQ};
    for (int i = 0; i < NUM_CMP; i++) begin
      if (rdSel == SEL_W'(i)) rdData = cmpReg[i];
    end
  end

endmodule

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int NUM_CMP = 3,
  parameter int SEL_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wrEn,
  input  logic [SEL_W-1:0]   wrSel,
  input  logic [NUM_CMP-1:0] hitVec,
  input  logic               armOk,
  output tmr_strobe_t        strb,
  output logic [NUM_CMP-1:0] armedVec,
  output logic [NUM_CMP-1:0] matchPulse
);

  // write decode: channel indices, then the counter, the rest ignored
  always_comb begin
    strb.cntLoad  = wrEn && (wrSel == SEL_W'(NUM_CMP));
    strb.cmpWrite = wrEn && (wrSel <  SEL_W'(NUM_CMP));
    strb.cmpIdx   = IDX_W'(wrSel);
  end

  for (genvar g = 0; g < NUM_CMP; g++) begin : gArm
    logic wrThis;
    logic fire;
    assign wrThis = strb.cmpWrite && (strb.cmpIdx == IDX_W'(g));
    assign fire   = armedVec[g] && hitVec[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        armedVec[g]   <= 1'b0;
        matchPulse[g] <= 1'b0;
      end else begin
        // a compare write overrides both the old event and its pulse
        matchPulse[g] <= fire && !wrThis;
        if (wrThis)    armedVec[g] <= armOk;
        else if (fire) armedVec[g] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/tick_match_timer.sv
module tick_match_timer
  import tick_timer_pkg::*;
#(
  parameter int NUM_CMP = 3,
  parameter int CNT_W   = 63,
  localparam int SEL_W  = $clog2(NUM_CMP + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wrEn,
  input  logic [SEL_W-1:0]   wrSel,
  input  logic [CNT_W:0]     wrData,
  input  logic [SEL_W-1:0]   rdSel,
  output logic [CNT_W:0]     rdData,
  output logic [CNT_W-1:0]   count,
  output logic [NUM_CMP-1:0] matchPulse
);

  tmr_strobe_t        strb;
  logic [NUM_CMP-1:0] hitVec;
  logic [NUM_CMP-1:0] armedVec;
  logic               armOk;

  tick_timer_ctrl #(.NUM_CMP(NUM_CMP), .SEL_W(SEL_W)) uCtrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(wrSel),
    .hitVec(hitVec), .armOk(armOk), .strb(strb),
    .armedVec(armedVec), .matchPulse(matchPulse)
  );

  tick_timer_dp #(.NUM_CMP(NUM_CMP), .CNT_W(CNT_W), .SEL_W(SEL_W)) uDp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .count(count),
    .hitVec(hitVec), .armOk(armOk)
  );

endmodule

// File: rtl/tick_match_timer_chk.sv
module tick_match_timer_chk #(
  parameter int NUM_CMP = 3,
  parameter int CNT_W   = 63,
  parameter int SEL_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wrEn,
  input logic [SEL_W-1:0]   wrSel,
  input logic [CNT_W:0]     wrData,
  input logic [CNT_W-1:0]   count,
  input logic [NUM_CMP-1:0] matchPulse,
  input logic [NUM_CMP-1:0] armedVec
);

  logic loadNow;
  assign loadNow = wrEn && (wrSel == SEL_W'(NUM_CMP));

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !loadNow |=> count == $past(count) + 1'b1);

  a_r3_count_load: assert property (@(posedge clk) disable iff (!rst_n)
    loadNow |=> count == $past(wrData[CNT_W-1:0]));

  for (genvar g = 0; g < NUM_CMP; g++) begin : gChk
    logic wrThis;
    assign wrThis = wrEn && (wrSel == SEL_W'(g));

    a_r5_disabled_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
      (wrThis && wrData[CNT_W]) |=> !armedVec[g]);

    a_r6_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      matchPulse[g] |=> !matchPulse[g]);

    a_r6_pulse_from_arm: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(matchPulse[g]) |-> $past(armedVec[g]) && !armedVec[g]);
  end

endmodule

bind tick_match_timer tick_match_timer_chk #(
  .NUM_CMP(NUM_CMP), .CNT_W(CNT_W), .SEL_W(SEL_W)
) uChk (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
  .count(count), .matchPulse(matchPulse), .armedVec(armedVec)
);

// File: tb/tick_match_timer_test.sv
module tick_match_timer_test;

  localparam int NUM_CMP = 3;
  localparam int CNT_W   = 63;
  localparam int SEL_W   = $clog2(NUM_CMP + 2);
  localparam logic [CNT_W:0] DIS = {1'b1, {CNT_W{1'b0}}};

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic [CNT_W:0]   data;
    logic [7:0]       idle;
    logic [15:0]      tag;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 64'd20,              8'd25, "R6"},
    '{3'd1, DIS | 64'd40,        8'd15, "R5"},
    '{3'd2, 64'd5,               8'd6,  "R5"},
    '{3'd3, 64'd100,             8'd2,  "R3"},
    '{3'd0, 64'd110,             8'd3,  "R7"},
    '{3'd0, 64'd120,             8'd25, "R7"},
    '{3'd1, 64'd150,             8'd2,  "R8"},
    '{3'd3, 64'd140,             8'd20, "R8"},
    '{3'd3, 64'd140,             8'd15, "R6"},
    '{3'd5, 64'h0000_0000_0000_0AAA, 8'd4, "R10"},
    '{3'd3, 64'd1000,            8'd0,  "R9"},
    '{3'd0, 64'd1010,            8'd0,  "R9"},
    '{3'd1, 64'd1010,            8'd0,  "R9"},
    '{3'd2, 64'd1010,            8'd15, "R9"},
    '{3'd3, 64'h7FFF_FFFF_FFFF_FFFD, 8'd0, "R2"},
    '{3'd0, 64'h7FFF_FFFF_FFFF_FFFF, 8'd6, "R2"}
  };

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               wrEn = 1'b0;
  logic [SEL_W-1:0]   wrSel = '0;
  logic [CNT_W:0]     wrData = '0;
  logic [SEL_W-1:0]   rdSel = '0;
  logic [CNT_W:0]     rdData;
  logic [CNT_W-1:0]   count;
  logic [NUM_CMP-1:0] matchPulse;

  int checks = 0;
  int fails  = 0;
  int stepNo = 0;
  int pulseSeen = 0;

  // reference state built from the requirements
  logic [CNT_W-1:0]   mCount;
  logic [CNT_W:0]     mCmp [NUM_CMP];
  logic [NUM_CMP-1:0] mArmed;
  logic [NUM_CMP-1:0] mPulse;

  tick_match_timer #(.NUM_CMP(NUM_CMP), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .count(count), .matchPulse(matchPulse)
  );

  always #10 clk = ~clk;

  task automatic check(input logic [CNT_W:0] act, input logic [CNT_W:0] exp,
                       input logic [15:0] tag, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic checkOutputs(input logic [15:0] tag);
    logic [CNT_W:0] expRd;
    expRd = '0;
    if (rdSel == SEL_W'(NUM_CMP)) expRd = {1'b0, mCount};
    else if (rdSel < SEL_W'(NUM_CMP)) expRd = mCmp[rdSel];
    check({1'b0, count}, {1'b0, mCount}, tag, "count");
    check({{(CNT_W+1-NUM_CMP){1'b0}}, matchPulse},
          {{(CNT_W+1-NUM_CMP){1'b0}}, mPulse}, tag, "matchPulse");
    check(rdData, expRd, "R4", "rdData");
    if (matchPulse != '0) pulseSeen++;
  endtask

  task automatic advance(input logic we, input logic [SEL_W-1:0] sel,
                         input logic [CNT_W:0] data);
    logic [NUM_CMP-1:0] nA, nP;
    for (int i = 0; i < NUM_CMP; i++) begin
      logic hit, wr;
      hit = mArmed[i] && (mCount == mCmp[i][CNT_W-1:0]);
      wr  = we && (sel == SEL_W'(i));
      nP[i] = hit && !wr;
      nA[i] = wr ? (!data[CNT_W] && (data[CNT_W-1:0] > mCount))
                 : (mArmed[i] && !hit);
      if (wr) mCmp[i] = data;
    end
    mArmed = nA;
    mPulse = nP;
    if (we && sel == SEL_W'(NUM_CMP)) mCount = data[CNT_W-1:0];
    else                              mCount = mCount + 1'b1;
  endtask

  // rel: data low bits are an offset from the count at the write
  task automatic step(input logic we, input logic [SEL_W-1:0] sel,
                      input logic [CNT_W:0] data, input logic rel,
                      input logic [15:0] tag);
    logic [CNT_W:0] d;
    @(negedge clk);
    checkOutputs(tag);
    d = rel ? {data[CNT_W], mCount + data[CNT_W-1:0]} : data;
    wrEn   = we;
    wrSel  = sel;
    wrData = d;
    stepNo++;
    rdSel  = SEL_W'(stepNo % (NUM_CMP + 1));
    advance(we, sel, d);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : main
    mCount = '0;
    mArmed = '0;
    mPulse = '0;
    for (int i = 0; i < NUM_CMP; i++) mCmp[i] = DIS;

    repeat (3) @(negedge clk);
    // R1: reset values observed while reset is held
    check({1'b0, count}, '0, "R1", "count in reset");
    check({{(CNT_W+1-NUM_CMP){1'b0}}, matchPulse}, '0, "R1", "pulse in reset");
    for (int i = 0; i < NUM_CMP; i++) begin
      rdSel = SEL_W'(i);
      #1 check(rdData, DIS, "R1", "compare reset value");
    end
    rdSel = '0;
    rst_n = 1'b1;
    advance(1'b0, '0, '0);

    for (int v = 0; v < NVEC; v++) begin
      step(1'b1, VECS[v].sel, VECS[v].data, 1'b0, VECS[v].tag);
      for (int k = 0; k < int'(VECS[v].idle); k++)
        step(1'b0, '0, '0, 1'b0, VECS[v].tag);
    end

    // R5: target equal to the count at the write does not arm
    step(1'b1, 3'd2, 64'd0, 1'b1, "R5");
    for (int k = 0; k < 6; k++) step(1'b0, '0, '0, 1'b0, "R5");

    // R6: target one ahead arms and fires
    step(1'b1, 3'd2, 64'd1, 1'b1, "R6");
    for (int k = 0; k < 6; k++) step(1'b0, '0, '0, 1'b0, "R6");

    // R7: compare write lands in the hit cycle and swallows the pulse
    step(1'b1, 3'd0, 64'd3, 1'b1, "R7");
    step(1'b0, '0, '0, 1'b0, "R7");
    step(1'b0, '0, '0, 1'b0, "R7");
    step(1'b1, 3'd0, DIS, 1'b0, "R7");
    for (int k = 0; k < 6; k++) step(1'b0, '0, '0, 1'b0, "R7");

    // R8: counter load lands in the hit cycle, pulse still fires
    step(1'b1, 3'd1, 64'd3, 1'b1, "R8");
    step(1'b0, '0, '0, 1'b0, "R8");
    step(1'b0, '0, '0, 1'b0, "R8");
    step(1'b1, 3'd3, 64'd500, 1'b0, "R8");
    for (int k = 0; k < 6; k++) step(1'b0, '0, '0, 1'b0, "R8");
    step(1'b1, 3'd3, 64'd499, 1'b0, "R8");
    for (int k = 0; k < 6; k++) step(1'b0, '0, '0, 1'b0, "R8");

    step(1'b0, '0, '0, 1'b0, "R2");
    // R6: pulses must have been observed during the run
    checks++;
    if (pulseSeen == 0) begin
      fails++;
      $display("FAIL R6 pulse cycles: actual %0d expected nonzero", pulseSeen);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule